// File: doc/BRIEF.md
# Multi-channel compare timer

An up-counting timer with a word-addressed register bus. The counter advances on prescaled ticks taken from one of several tick-enable inputs, chosen by a field in the control register. Three compare registers set status flags when the counter reaches their values. A rollover flag records a wrap from the top of the count range. One level interrupt line combines the status flags with an enable mask and the timer enable bit.

There are two counting modes. In restart mode the counter returns to zero after it reaches compare channel 1, so that channel sets the period. In free-run mode the counter runs through its whole range. A software reset bit in the control register returns every register to its reset value. It keeps a defined group of control bits, and the bit clears itself. Two capture registers are part of the map but always read as zero.

Top module: `cmp_timer`

## Requirements
- R1: Word offsets are 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2 and 9 counter. Reads of the capture registers and of any unmapped offset return 0. Writes to them change nothing.
- R2: The prescaler register stores 12 bits. While enabled, the counter advances once every (prescaler + 1) selected ticks. A prescaler write restarts the division.
- R3: Control bits 8:6 choose the tick input with that index. Code 0 chooses no clock, and the counter then holds.
- R4: A status write clears the bits where the written low 6 bits are 1. A flag event in the same cycle wins over the clear. Interrupt enable stores only the low 6 bits. Flag positions are: compare 1–3 at bits 0–2, capture at bits 3–4 (never set), rollover at bit 5.
- R5: irq_o is high exactly when (status AND interrupt enable) is nonzero and control bit 0 (enable) is set.
- R6: With control bit 9 (free-run) clear, a step taken while the count equals compare 1 returns the count to 0. A compare flag is set on the step that makes the count equal that channel's value.
- R7: In free-run mode, a step from the all-ones count wraps to 0 and sets the rollover flag.
- R8: Matches on compare 2 and compare 3 set their flags and leave the count sequence unchanged.
- R9: Writing compare 1 while free-run is clear resets the count to 0.
- R10: Setting enable (bit 0) from 0 with enable-mode (bit 1) set restarts the count at 0. If enable-mode is clear, the count resumes. Clearing enable freezes the count.
- R11: After rst_ni, control, prescaler, status, interrupt enable, counter and capture read 0, and each compare register reads all ones over the counter width.
- R12: A control write with bit 15 set resets all other registers to their R11 values. Control keeps only written bits 0–8 that can be stored, and bit 15 reads 1 for one cycle and then 0. Control bits in mask 0x7C14 are never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| src_tick_i | input | 2**SRC_W | Tick-enable inputs, indexed by the clock-source code |
| irq_o | output | 1 | Level interrupt |

## Verification
Two collisions matter. A status clear can land in the same cycle as a compare or rollover event. A compare-1 write can land on the cycle where the counter steps. The bench provokes the first with back-to-back all-ones status writes while the counter runs at full tick rate with a short period. It provokes the second with compare-1 writes that fall on stepping cycles. A behavioural model, updated on every edge, decides each cycle that the event's flag survives the clear and that the write's count reset overrides the step. The bench compares the read bus and the interrupt line against this model on every cycle.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_PRE  = 1;
  localparam int unsigned ADDR_STAT = 2;
  localparam int unsigned ADDR_IEN  = 3;
  localparam int unsigned ADDR_CMP0 = 4;
  localparam int unsigned ADDR_CMP1 = 5;
  localparam int unsigned ADDR_CMP2 = 6;
  localparam int unsigned ADDR_CAP0 = 7;
  localparam int unsigned ADDR_CAP1 = 8;
  localparam int unsigned ADDR_CNT  = 9;

  localparam int unsigned CMP_NUM = 3;
  localparam int unsigned FLAG_W  = 6;

  localparam int unsigned CTRL_EN      = 0;
  localparam int unsigned CTRL_ENMOD   = 1;
  localparam int unsigned CTRL_SRC_LSB = 6;
  localparam int unsigned CTRL_FREE    = 9;
  localparam int unsigned CTRL_SWR     = 15;

  localparam logic [31:0] CTRL_DROP_MASK = 32'h0000_7C14;
  localparam logic [31:0] CTRL_KEEP_MASK = 32'h0000_01FF;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             step_o
);
  logic [PRE_W-1:0] pc_q;
  logic             last;

  assign last   = (pc_q == div_i);
  assign step_o = en_i & tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pc_q <= '0;
    else if (clr_i || !en_i)   pc_q <= '0;
    else if (tick_i)           pc_q <= last ? '0 : pc_q + 1'b1;
  end

  // R2: the phase counter never passes the divide value
  p_pc_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= div_i);

  // R2: a tick short of the divide value advances the phase without a step
  p_pc_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !clr_i && !last) |=> (pc_q == $past(pc_q) + 1'b1));
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CMP_NUM = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            step_i,
  input  logic                            clear_i,
  input  logic                            free_i,
  input  logic [CMP_NUM-1:0][CNT_W-1:0]   cmp_i,
  output logic [CNT_W-1:0]                cnt_o,
  output logic [CMP_NUM-1:0]              hit_o,
  output logic                            roll_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             at_max, period_end;

  assign at_max     = (cnt_q == CNT_MAX);
  assign period_end = !free_i && (cnt_q == cmp_i[0]);
  assign cnt_nxt    = (period_end || at_max) ? '0 : cnt_q + 1'b1;
  assign roll_o     = step_i && at_max && !period_end;

  for (genvar k = 0; k < CMP_NUM; k++) begin : g_hit
    assign hit_o[k] = step_i && (cnt_nxt == cmp_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R10 / R3: no step, no clear -> count frozen
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(cnt_q));

  // R6: restart mode period end returns to zero
  p_period_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !free_i && cnt_q == cmp_i[0]) |=> (cnt_q == '0));

  // R7: free-run wrap from the top of the range
  p_roll_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && free_i && at_max) |=> (cnt_q == '0));

  // R8: ordinary step increments
  p_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !at_max && !(!free_i && cnt_q == cmp_i[0]))
      |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned SRC_W  = 3,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [(1<<SRC_W)-1:0]   src_tick_i,
  output logic                    irq_o
);
  logic [31:0]                      ctrl_q;
  logic [PRE_W-1:0]                 pre_q;
  logic [FLAG_W-1:0]                stat_q, ien_q, stat_clr, stat_set;
  logic [CMP_NUM-1:0][CNT_W-1:0]    cmp_q;
  logic [CNT_W-1:0]                 cnt;
  logic [CMP_NUM-1:0]               hit;
  logic                             roll;

  logic wr, wr_ctrl, wr_pre, wr_stat, wr_ien, swr;
  logic [CMP_NUM-1:0] wr_cmp;
  logic en, free, tick_sel, step, en_restart, cnt_clr;
  logic [SRC_W-1:0] src;

  assign wr      = req_i & we_i;
  assign wr_ctrl = wr && (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_pre  = wr && (addr_i == ADDR_W'(ADDR_PRE));
  assign wr_stat = wr && (addr_i == ADDR_W'(ADDR_STAT));
  assign wr_ien  = wr && (addr_i == ADDR_W'(ADDR_IEN));
  assign swr     = wr_ctrl & wdata_i[CTRL_SWR];

  for (genvar k = 0; k < CMP_NUM; k++) begin : g_cmp
    assign wr_cmp[k] = wr && (addr_i == ADDR_W'(ADDR_CMP0 + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_q[k] <= '1;
      else if (swr)       cmp_q[k] <= '1;
      else if (wr_cmp[k]) cmp_q[k] <= wdata_i[CNT_W-1:0];
    end
  end

  assign en   = ctrl_q[CTRL_EN];
  assign free = ctrl_q[CTRL_FREE];
  assign src  = ctrl_q[CTRL_SRC_LSB +: SRC_W];
  assign tick_sel = (src != '0) && src_tick_i[src];

  assign en_restart = wr_ctrl && !swr && !en &&
                      wdata_i[CTRL_EN] && wdata_i[CTRL_ENMOD];
  assign cnt_clr    = swr | en_restart | (wr_cmp[0] & ~free);

  cmp_timer_prescale #(.PRE_W(PRE_W)) i_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .tick_i (tick_sel),
    .clr_i  (wr_pre | swr),
    .div_i  (pre_q),
    .step_o (step)
  );

  cmp_timer_count #(.CNT_W(CNT_W), .CMP_NUM(CMP_NUM)) i_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .clear_i (cnt_clr),
    .free_i  (free),
    .cmp_i   (cmp_q),
    .cnt_o   (cnt),
    .hit_o   (hit),
    .roll_o  (roll)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (swr)     ctrl_q <= (wdata_i & ~CTRL_DROP_MASK & CTRL_KEEP_MASK) |
                                (32'd1 << CTRL_SWR);
    else if (wr_ctrl) ctrl_q <= wdata_i & ~CTRL_DROP_MASK;
    else              ctrl_q[CTRL_SWR] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (swr)    pre_q <= '0;
    else if (wr_pre) pre_q <= wdata_i[PRE_W-1:0];
  end

  // hardware set wins over a same-cycle clear
  assign stat_clr = wr_stat ? wdata_i[FLAG_W-1:0] : '0;
  assign stat_set = {roll, 2'b00, hit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stat_q <= '0;
    else if (swr)  stat_q <= '0;
    else           stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (swr)    ien_q <= '0;
    else if (wr_ien) ien_q <= wdata_i[FLAG_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(ADDR_CTRL): rdata_o = ctrl_q;
      ADDR_W'(ADDR_PRE):  rdata_o = 32'(pre_q);
      ADDR_W'(ADDR_STAT): rdata_o = 32'(stat_q);
      ADDR_W'(ADDR_IEN):  rdata_o = 32'(ien_q);
      ADDR_W'(ADDR_CMP0): rdata_o = 32'(cmp_q[0]);
      ADDR_W'(ADDR_CMP1): rdata_o = 32'(cmp_q[1]);
      ADDR_W'(ADDR_CMP2): rdata_o = 32'(cmp_q[2]);
      ADDR_W'(ADDR_CNT):  rdata_o = 32'(cnt);
      default:            rdata_o = '0;
    endcase
  end

  assign irq_o = en && ((stat_q & ien_q) != '0);

  // R4: a clear with no coincident event leaves the written bits at 0
  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && stat_set == '0) |=> ((stat_q & $past(wdata_i[FLAG_W-1:0])) == '0));

  // R12: software reset bit drops after one cycle
  p_swr_self_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTRL_SWR] && !swr) |=> !ctrl_q[CTRL_SWR]);

  // R9: compare-1 write in restart mode zeroes the count
  p_cmp1_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmp[0] && !free) |=> (cnt == '0));

  // R12: software reset restores compare registers
  p_swr_cmp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr |=> (cmp_q[1] == '1 && stat_q == '0 && ien_q == '0));
endmodule

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
  localparam int W = 12;
  localparam logic [31:0] CM = (32'd1 << W) - 1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tick = '0;
  logic        irq;

  int checks = 0, errors = 0;
  int tick_mode = 0;
  string phase = "R11";

  always #5 clk = ~clk;

  cmp_timer #(.CNT_W(W)) i_cmp_timer (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_tick_i(tick), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_ctrl, m_pr, m_sr, m_ir, m_cnt, m_pc;
  logic [31:0] m_ocr [3];

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return m_pr;
      4'd2: return m_sr;
      4'd3: return m_ir;
      4'd4: return m_ocr[0];
      4'd5: return m_ocr[1];
      4'd6: return m_ocr[2];
      4'd9: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    logic w, en, frr, tk, stp;
    logic [2:0] src;
    logic [31:0] n, setv, clr;
    if (!rst_ni) begin
      m_ctrl = 0; m_pr = 0; m_sr = 0; m_ir = 0; m_cnt = 0; m_pc = 0;
      for (int k = 0; k < 3; k++) m_ocr[k] = CM;
    end else begin
      w = req && we;
      if (w && addr == 0 && wdata[15]) begin
        m_ctrl = (wdata & 32'h1EB) | 32'h8000;
        m_pr = 0; m_sr = 0; m_ir = 0; m_cnt = 0; m_pc = 0;
        for (int k = 0; k < 3; k++) m_ocr[k] = CM;
      end else begin
        en = m_ctrl[0]; frr = m_ctrl[9]; src = m_ctrl[8:6];
        tk = en && src != 0 && tick[src];
        stp = tk && (m_pc == m_pr);
        if (!en) m_pc = 0;
        else if (tk) m_pc = stp ? 0 : m_pc + 1;
        setv = 0;
        if (stp) begin
          if (!frr && m_cnt == m_ocr[0]) n = 0;
          else if (m_cnt == CM) begin n = 0; setv[5] = 1'b1; end
          else n = m_cnt + 1;
          for (int k = 0; k < 3; k++) if (n == m_ocr[k]) setv[k] = 1'b1;
          m_cnt = n;
        end
        m_ctrl[15] = 1'b0;
        clr = (w && addr == 2) ? (wdata & 32'h3F) : 0;
        m_sr = (m_sr & ~clr) | setv;
        if (w) case (addr)
          4'd0: begin
            if (!en && wdata[0] && wdata[1]) m_cnt = 0;
            m_ctrl = wdata & ~32'h7C14;
          end
          4'd1: begin m_pr = wdata & 32'hFFF; m_pc = 0; end
          4'd3: m_ir = wdata & 32'h3F;
          4'd4: begin m_ocr[0] = wdata & CM; if (!frr) m_cnt = 0; end
          4'd5: m_ocr[1] = wdata & CM;
          4'd6: m_ocr[2] = wdata & CM;
          default: ;
        endcase
      end
    end
  end

  task automatic compare();
    logic exp_irq;
    checks++;
    if (rdata !== m_read(addr)) begin
      errors++;
      $display("FAIL %s addr %0d act %h exp %h", phase, addr, rdata, m_read(addr));
    end
    exp_irq = ((m_sr & m_ir) != 0) && m_ctrl[0];
    checks++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s/R5 irq act %b exp %b", phase, irq, exp_irq);
    end
  endtask

  task automatic drive_tick();
    case (tick_mode)
      0: tick = 8'hFF;
      1: tick = 8'($urandom);
      default: tick = 8'h00;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); compare();
      req = 0; we = 0; addr = addr + 4'd1; drive_tick();
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); compare();
    req = 1; we = 1; addr = a; wdata = d; drive_tick();
  endtask

  task automatic expect_const(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); compare();
    req = 0; we = 0; addr = a; drive_tick();
    #1;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s addr %0d act %h exp %h", tag, a, rdata, e);
    end
  endtask

  function automatic logic [31:0] mk(input bit e, input bit m, input int s, input bit f);
    return 32'(e) | (32'(m) << 1) | (32'(s) << 6) | (32'(f) << 9);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R11 reset values
    expect_const(0, 0, "R11"); expect_const(1, 0, "R11");
    expect_const(2, 0, "R11"); expect_const(3, 0, "R11");
    expect_const(4, CM, "R11"); expect_const(5, CM, "R11");
    expect_const(6, CM, "R11"); expect_const(9, 0, "R11");
    expect_const(7, 0, "R11"); expect_const(8, 0, "R11");
    // R1 capture and unmapped offsets
    phase = "R1";
    wr(7, 32'hDEAD_BEEF); wr(8, 32'h1234_5678); wr(4'd12, 32'hFFFF_FFFF);
    expect_const(7, 0, "R1"); expect_const(8, 0, "R1"); expect_const(4'd12, 0, "R1");
    idle(16);
    // R3 clock source selection
    phase = "R3"; tick_mode = 0;
    wr(0, mk(1, 1, 0, 0)); idle(20);
    expect_const(9, 0, "R3");
    wr(0, mk(0, 0, 0, 0)); tick_mode = 1;
    wr(0, mk(1, 1, 3, 0)); idle(50);
    wr(0, mk(1, 0, 5, 0)); idle(40);
    // R2 prescaler
    phase = "R2";
    wr(1, 2); idle(60);
    wr(1, 32'hFFFF_F003); idle(40);
    wr(1, 32'd4095); idle(30);
    wr(1, 0); tick_mode = 0;
    wr(0, mk(1, 0, 3, 0)); idle(10);
    // R6 / R8 restart mode with three compares
    phase = "R6";
    wr(3, 32'h3F); wr(4, 20); wr(5, 7); wr(6, 15); idle(80);
    phase = "R8";
    wr(5, 19); wr(6, 0); idle(60);
    // R4 clears colliding with events
    phase = "R4";
    wr(4, 3);
    for (int i = 0; i < 40; i++) begin wr(2, 32'hFFFF_FFFF); idle(i % 3); end
    wr(4, 20);
    // R5 interrupt gating
    phase = "R5";
    wr(3, 0); idle(5); wr(3, 32'hFFFF_FF02); idle(30);
    wr(0, mk(0, 0, 3, 0)); idle(10);
    wr(0, mk(1, 0, 3, 0)); idle(10);
    // R10 enable/disable
    phase = "R10";
    wr(0, mk(0, 1, 3, 0)); idle(12);
    wr(0, mk(1, 0, 3, 0)); idle(6);
    wr(0, mk(0, 0, 3, 0)); idle(4);
    wr(0, mk(1, 1, 3, 0)); idle(10);
    // R9 compare-1 write restarts count
    phase = "R9";
    wr(4, 100); idle(40); wr(4, 30); idle(13); wr(4, 30); idle(40);
    tick_mode = 1; wr(4, 25); idle(30); tick_mode = 0;
    // R7 free-run rollover
    phase = "R7";
    wr(0, mk(1, 0, 3, 1)); wr(3, 32'h20); wr(4, 50); idle(4400);
    wr(2, 32'h3F); wr(3, 32'h21); idle(200);
    // R12 storage mask and soft reset
    phase = "R12";
    wr(0, 32'hFFFF_7FFF); idle(20);
    wr(1, 5); wr(3, 32'h3F);
    wr(0, 32'hFFFF_FFFF);
    expect_const(0, 32'h0000_81EB, "R12");
    expect_const(0, 32'h0000_01EB, "R12");
    expect_const(1, 0, "R12"); expect_const(3, 0, "R12");
    expect_const(4, CM, "R12");
    idle(60);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule